// File: doc/BRIEF.md
# SPI Host Byte Transfer Engine

This block is the transfer core of a full-duplex SPI host. It takes bytes from a transmit-buffer interface and shifts each one out on MOSI, eight bits per byte. In the same clock periods it collects eight bits from MISO and hands the finished byte to a receive-buffer interface. SCK is made by a programmable divider of the system clock. A double-speed setting forces SCK to half the system clock. Timing is fixed to mode 0: SCK idles low, MOSI changes on the falling edge, and MISO is sampled on the rising edge.

The engine sleeps until the transmit buffer reports data, which happens when firmware writes a byte. It then pops that byte and starts the clock. At every byte boundary it pops the next byte if one is waiting, so back-to-back bytes follow each other at the same SCK spacing. If the buffer is empty at a boundary, the clock stops and the engine goes idle. Each completed byte sets a sticky end-of-transfer flag, which becomes an interrupt request when enabled. The slave-select line is never touched by the engine: it is a plain register output that firmware writes.

Top module: `spi_host_engine`

## Requirements
- R1: While idle, a high `tx_valid` makes the engine assert `tx_pop` in that same cycle, load `tx_data`, and exchange exactly 8 bits for that byte (8 rising SCK edges). `tx_pop` is never high while `tx_valid` is low.
- R2: At the final falling SCK edge of a byte, if `tx_valid` is high, the next byte is popped in that cycle. The first rising edge of the new byte then follows the previous rising edge by the same full SCK period as inside a byte.
- R3: If `tx_valid` is low at the final falling edge of a byte, the engine goes idle. SCK stays low and makes no further edges until `tx_valid` is high again.
- R4: With `lsb_first`=1, bit 0 of each byte is sent first on MOSI, and the first bit received lands in bit 0 of `rx_data`. With `lsb_first`=0, bit 7 goes first in both directions.
- R5: SCK is low whenever the engine is idle, MOSI changes only while SCK is low, and MISO is captured at the rising SCK edge.
- R6: With `dbl_speed`=0, each SCK half-period lasts 2^r system clocks, where r = `rate_sel` (0..6), so SCK is the system clock divided by 2, 4, 8, 16, 32, 64 or 128. A `rate_sel` of 7 behaves like 6. With `dbl_speed`=1, SCK is the system clock divided by 2 whatever `rate_sel` holds.
- R7: In the cycle right after a byte's final falling SCK edge, `rx_push` is high for exactly one cycle, and `rx_data` holds the received byte.
- R8: A completed byte sets the end-of-transfer flag, which stays set until an `eot_clr` pulse (a completion in the same cycle wins). `irq` equals the flag ANDed with `irq_en`.
- R9: `cs_n` resets to 1 and takes `cs_val_n` only in a cycle with `cs_wr` high. The engine never changes it.
- R10: `busy` rises in the cycle after the first byte is popped, is high at every rising SCK edge, and falls at the final falling edge of the last byte.
- R11: Reset leaves SCK low, `busy`, `rx_push`, `irq` and `tx_pop` low (with `tx_valid` low), and `cs_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | SCK divider exponent |
| dbl_speed | input | 1 | Force SCK to clock/2 |
| lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| irq_en | input | 1 | Interrupt enable for the end-of-transfer flag |
| tx_valid | input | 1 | Transmit buffer holds a byte |
| tx_data | input | 8 | Head byte of the transmit buffer |
| tx_pop | output | 1 | Take the head byte of the transmit buffer |
| rx_push | output | 1 | Write `rx_data` into the receive buffer |
| rx_data | output | 8 | Received byte |
| eot_clr | input | 1 | Clear the end-of-transfer flag |
| irq | output | 1 | Interrupt request |
| cs_wr | input | 1 | Write strobe for the slave-select register |
| cs_val_n | input | 1 | Value to store in the slave-select register |
| cs_n | output | 1 | Slave-select output, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Byte exchange in progress |

## Verification
The bench sweeps every `rate_sel` value from 0 to 7 with `dbl_speed` off and on, under both bit orders, using bursts of one, two and three bytes. The rate sweep separates each divider setting, and shows that code 7 saturates and that double speed overrides the rate. The two bit orders use asymmetric byte values, so a reversed byte or a reversed shift direction is caught on MOSI and on `rx_data` separately. The burst lengths separate a clean stop on an empty buffer from a gap-free chain: the SCK period is measured across each byte boundary and compared with the period inside a byte.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } eng_state_e;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
  parameter int unsigned RATE_W   = 3,
  parameter int unsigned MAX_RATE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              dbl_speed,
  output logic              tick
);
  localparam int unsigned CNT_W = (MAX_RATE > 0) ? MAX_RATE : 1;

  logic [RATE_W-1:0] eff_rate;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    eff_rate = (rate_sel > RATE_W'(MAX_RATE)) ? RATE_W'(MAX_RATE) : rate_sel;
    limit    = dbl_speed ? '0 : CNT_W'((32'd1 << eff_rate) - 32'd1);
    tick     = run && (cnt_q == limit);
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              lsb_first,
  input  logic              shift_out,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_byte
);
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)           tx_d = load_data;
    else if (shift_out) tx_d = lsb_first ? (tx_q >> 1) : (tx_q << 1);
    rx_d = rx_q;
    if (sample) rx_d = lsb_first ? {miso, rx_q[DATA_W-1:1]} : {rx_q[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = lsb_first ? tx_q[0] : tx_q[DATA_W-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
  import spi_host_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned RATE_W   = 3,
  parameter int unsigned MAX_RATE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              dbl_speed,
  input  logic              lsb_first,
  input  logic              irq_en,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_data,
  input  logic              eot_clr,
  output logic              irq,
  input  logic              cs_wr,
  input  logic              cs_val_n,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              busy
);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  eng_state_e        state_q, state_d;
  logic              sck_q, sck_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              push_q, push_d;
  logic [DATA_W-1:0] rxd_q, rxd_d;
  logic              eot_q, eot_d;
  logic              cs_q, cs_d;

  logic              run, tick, rise, fall, last_bit, done, start;
  logic [DATA_W-1:0] rx_byte;

  assign run = (state_q == ST_SHIFT);

  spi_rate_gen #(.RATE_W(RATE_W), .MAX_RATE(MAX_RATE)) i_rate (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .run      (run),
    .rate_sel (rate_sel),
    .dbl_speed(dbl_speed),
    .tick     (tick)
  );

  always_comb begin
    rise     = tick && !sck_q;
    fall     = tick && sck_q;
    last_bit = (bit_q == BIT_W'(DATA_W-1));
    done     = fall && last_bit;
    start    = (state_q == ST_IDLE) && tx_valid;
    tx_pop   = start || (done && tx_valid);
  end

  spi_byte_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .load     (tx_pop),
    .load_data(tx_data),
    .lsb_first(lsb_first),
    .shift_out(fall),
    .sample   (rise),
    .miso     (miso),
    .mosi     (mosi),
    .rx_byte  (rx_byte)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start) state_d = ST_SHIFT;
      ST_SHIFT: if (done && !tx_valid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    sck_d  = tick ? !sck_q : sck_q;
    bit_d  = bit_q;
    if (tx_pop)    bit_d = '0;
    else if (fall) bit_d = bit_q + 1'b1;
    push_d = done;
    rxd_d  = done ? rx_byte : rxd_q;
    eot_d  = eot_q;
    if (done)         eot_d = 1'b1;
    else if (eot_clr) eot_d = 1'b0;
    cs_d   = cs_wr ? cs_val_n : cs_q;
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      bit_q   <= '0;
      push_q  <= 1'b0;
      rxd_q   <= '0;
      eot_q   <= 1'b0;
      cs_q    <= 1'b1;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      bit_q   <= bit_d;
      push_q  <= push_d;
      rxd_q   <= rxd_d;
      eot_q   <= eot_d;
      cs_q    <= cs_d;
    end
  end

  assign sck     = sck_q;
  assign busy    = run;
  assign rx_push = push_q;
  assign rx_data = rxd_q;
  assign irq     = eot_q && irq_en;
  assign cs_n    = cs_q;

  // R3
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !busy |-> !sck);
  // R1
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    tx_pop |-> tx_valid);
  // R7
  push_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    rx_push |-> (!sck && $past(sck)));
  // R7
  push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    rx_push |=> !rx_push);
  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (sck && $past(sck)) |-> $stable(mosi));
  // R8
  eot_irq_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    rx_push |-> (irq == irq_en));
  // R9
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !cs_wr |=> $stable(cs_n));
  // R10
  busy_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(sck) |-> busy);
endmodule

// File: tb/test_spi_host_engine.sv
`timescale 1ns/1ps
module test_spi_host_engine;
  logic       clk;
  logic       rst_n;
  logic [2:0] rate_sel;
  logic       dbl_speed, lsb_first, irq_en;
  logic       tx_valid, tx_pop, rx_push, eot_clr, irq;
  logic [7:0] tx_data, rx_data;
  logic       cs_wr, cs_val_n, cs_n, sck, mosi, miso, busy;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [7:0] txb [4];
  logic [7:0] slb [4];
  logic [7:0] got [4];
  int   n_bytes = 0;
  int   tx_idx  = 0;
  int   rises, pushes, half, cyc, last_rise;
  logic prev_sck, prev_mosi, mon_on, cur_lsb;

  spi_host_engine i_spi_host_engine (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .dbl_speed(dbl_speed),
    .lsb_first(lsb_first), .irq_en(irq_en), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .eot_clr(eot_clr),
    .irq(irq), .cs_wr(cs_wr), .cs_val_n(cs_val_n), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso), .busy(busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign tx_valid = (tx_idx < n_bytes);
  assign tx_data  = txb[tx_idx[1:0]];

  always @(posedge clk) if (tx_pop) tx_idx <= tx_idx + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bpos(input int i, input logic lsb);
    return lsb ? (i % 8) : (7 - (i % 8));
  endfunction

  // Slave model and line monitor, sampled away from the active edge
  initial begin
    cyc = 0; rises = 0; pushes = 0; last_rise = 0; half = 1;
    prev_sck = 1'b0; prev_mosi = 1'b0; mon_on = 1'b0; cur_lsb = 1'b0; miso = 1'b0;
  end

  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (sck && !prev_sck) begin
        check(busy, "R10 busy at rising SCK", busy, 1);
        if (rises > 0)
          check(cyc - last_rise == 2 * half, (rises % 8 == 0) ? "R2 period across boundary" : "R6 SCK period",
                cyc - last_rise, 2 * half);
        if (rises / 8 < 4) got[rises / 8][bpos(rises, cur_lsb)] = mosi;
        last_rise = cyc;
        rises++;
      end
      if (!sck && prev_sck && (rises / 8 < 4)) miso = slb[rises / 8][bpos(rises, cur_lsb)];
      if (sck && prev_sck) check(mosi == prev_mosi, "R5 MOSI stable while SCK high", mosi, prev_mosi);
      if (rx_push) begin
        if (pushes < 4) begin
          check(rx_data == slb[pushes], "R7/R4 received byte", rx_data, slb[pushes]);
          check(got[pushes] == txb[pushes], "R4 MOSI byte", got[pushes], txb[pushes]);
        end
        pushes++;
        if (pushes == n_bytes) check(!busy && !sck, "R10 busy low after last byte", busy, 0);
      end
    end
    prev_sck  = sck;
    prev_mosi = mosi;
  end

  task automatic burst(input int rate, input bit dbl, input bit lsb, input int n, input int cfg);
    @(negedge clk);
    rate_sel  = 3'(rate);
    dbl_speed = dbl;
    lsb_first = lsb;
    cur_lsb   = lsb;
    half      = dbl ? 1 : (1 << ((rate > 6) ? 6 : rate));
    for (int k = 0; k < 4; k++) begin
      txb[k] = 8'(cfg * 29 + k * 83 + 8'h5A);
      slb[k] = 8'(cfg * 53 + k * 19) ^ 8'hC3;
      got[k] = 8'h00;
    end
    rises  = 0;
    pushes = 0;
    miso   = slb[0][bpos(0, lsb)];
    mon_on = 1'b1;
    tx_idx = 0;
    n_bytes = n;
    while (pushes < n) @(negedge clk);
    repeat (3 * half + 4) @(negedge clk);
    check(rises == 8 * n, "R1 eight rising edges per byte", rises, 8 * n);
    check(tx_idx == n, "R2 bytes popped", tx_idx, n);
    check(pushes == n, "R3 no extra byte after empty", pushes, n);
    check(!busy && !sck, "R3 idle with SCK low", sck, 0);
    mon_on = 1'b0;
    n_bytes = 0;
    tx_idx  = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rate_sel = 3'd0; dbl_speed = 1'b0; lsb_first = 1'b0; irq_en = 1'b1;
    eot_clr = 1'b0; cs_wr = 1'b0; cs_val_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(!sck, "R11 sck", sck, 0);
    check(!busy, "R11 busy", busy, 0);
    check(cs_n, "R11 cs_n", cs_n, 1);
    check(!irq && !rx_push && !tx_pop, "R11 irq/push/pop", irq, 0);

    // R9 value change without strobe is ignored, strobe takes it
    cs_val_n = 1'b0;
    @(negedge clk);
    check(cs_n, "R9 cs_n without strobe", cs_n, 1);
    cs_wr = 1'b1;
    @(negedge clk);
    cs_wr = 1'b0; cs_val_n = 1'b1;
    @(negedge clk);
    check(!cs_n, "R9 cs_n after write", cs_n, 0);

    for (int r = 0; r < 8; r++)
      for (int d = 0; d < 2; d++)
        for (int l = 0; l < 2; l++) begin
          int cfg;
          cfg = r * 4 + d * 2 + l;
          burst(r, d[0], l[0], 1 + (cfg % 3), cfg);
          // R8 flag set and reported through irq
          check(irq, "R8 irq after completion", irq, 1);
          eot_clr = 1'b1;
          @(negedge clk);
          eot_clr = 1'b0;
          @(negedge clk);
          check(!irq, "R8 irq after clear", irq, 0);
        end

    check(!cs_n, "R9 cs_n untouched by transfers", cs_n, 0);

    // R8 enable gates the request, flag stays
    irq_en = 1'b0;
    burst(2, 1'b0, 1'b1, 2, 40);
    check(!irq, "R8 irq masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    check(irq, "R8 flag kept while masked", irq, 1);

    cs_wr = 1'b1; cs_val_n = 1'b1;
    @(negedge clk);
    cs_wr = 1'b0;
    @(negedge clk);
    check(cs_n, "R9 cs_n released", cs_n, 1);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule